// File: doc/BRIEF.md
# Two-Section Translation Buffer Lookup

This block finds the translation entry for a virtual address. It holds two groups of entries. The first group is set-associative: 8 ways by 256 sets, and every entry in it uses one page size that is shared and supplied on an input. The second group is a small fully associative pool, and each entry in it carries its own page size. Each entry maps a pair of adjacent pages, one even and one odd. Because of this, the compare drops the address bits up to and including the page-size bit.

A request gives a virtual address and the current address-space ID. One cycle later the block reports hit or miss and the flat index of the first matching entry. The set-associative group is searched first, in way order, and the pool follows in slot order. Entries are loaded one at a time through a write port addressed by flat index. Permission checks and victim selection are left to the surrounding logic.

Top module: `tlb_lookup`

## Requirements
- R1: After reset, rsp_valid, rsp_hit and rsp_idx are zero and every entry is invalid, so any lookup misses until entries are written.
- R2: A request with lk_valid high at a clock edge gives rsp_valid high after that edge, and the result holds for one cycle. With no request, rsp_valid and rsp_hit are low and rsp_idx is zero.
- R3: A set-associative lookup reads set s = bits [7:0] of (va >> (cfg_sa_ps+1)). Way w of set s sits at flat index w*256+s, and it can only hit a lookup whose address selects set s.
- R4: The stored tag holds virtual address bits [47:13]. An entry with page size ps matches when (va >> (ps+1)) equals (tag >> (ps+1-13)). Address bits at or below ps, including the even/odd page bit, take no part in the compare.
- R5: An entry is usable when its global flag is set or when its stored ASID equals lk_asid.
- R6: An entry written with its enable bit clear never hits.
- R7: When several ways of one set match, the lowest way is reported.
- R8: A match in the set-associative section wins over any match in the pool.
- R9: Pool slot k has flat index 2048+k and uses its own stored page size for the compare. It ignores the set bits, and the lowest matching slot wins.
- R10: On a miss, rsp_hit is low and rsp_idx is zero.
- R11: Set-associative entries use cfg_sa_ps for the compare. The page size written with them has no effect.
- R12: A write takes effect at the clock edge that captures it. A lookup captured at that same edge still sees the old contents, and the next lookup sees the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_sa_ps | input | 6 | Page size (log2 bytes) shared by the set-associative section |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | 12 | Flat index of the entry written |
| wr_e | input | 1 | Entry enable bit |
| wr_tag | input | 35 | Virtual address bits [47:13] |
| wr_ps | input | 6 | Page size; stored only by pool entries |
| wr_asid | input | 10 | Address-space ID of the entry |
| wr_g | input | 1 | Global flag; match any ASID |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 48 | Virtual address to translate |
| lk_asid | input | 10 | Current address-space ID |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_hit | output | 1 | Some entry matched |
| rsp_idx | output | 12 | Flat index of the first match, zero on miss |

## Verification
Every lookup result appears exactly one clock edge after the request is captured. The bench drives a request at a falling edge, drops lk_valid at the next falling edge, and samples the response there, between the capturing edge and the following one. It then checks that rsp_valid has fallen one cycle later still. Writes are applied one cycle before the lookups that rely on them, except in the same-edge case, where the lookup is expected to miss and a second lookup is expected to hit. The set sweep covers all 256 sets with both a matching and a non-matching ASID. The pool sweep covers all 64 slots with ten different page sizes.

// File: rtl/tlb_lookup_pkg.sv
package tlb_lookup_pkg;

  localparam int TAG_LSB = 13;

  // page number of an address: drop the page offset and the even/odd bit
  function automatic logic [63:0] page_pair_no(input logic [63:0] va, input logic [5:0] ps);
    return va >> ({1'b0, ps} + 7'd1);
  endfunction

  // tag compare by masking: keep only the bits above the page-pair boundary
  function automatic logic tag_same(input logic [63:0] va, input logic [63:0] tag,
                                    input logic [5:0] ps);
    logic [63:0] keep;
    keep = {64{1'b1}} << ({1'b0, ps} + 7'd1);
    return ((va ^ (tag << TAG_LSB)) & keep) == 64'd0;
  endfunction

  function automatic logic entry_hit(input logic e, input logic g, input logic asid_eq,
                                     input logic [63:0] va, input logic [63:0] tag,
                                     input logic [5:0] ps);
    return e && (g || asid_eq) && tag_same(va, tag, ps);
  endfunction

endpackage

// File: rtl/tlb_sa_section.sv
module tlb_sa_section
  import tlb_lookup_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int ASID_W  = 10,
  parameter int SA_WAYS = 8,
  parameter int SA_SETS = 256,
  localparam int SET_W  = $clog2(SA_SETS),
  localparam int WAY_W  = $clog2(SA_WAYS),
  localparam int TAG_W  = VA_W - TAG_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        gps,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [SET_W-1:0]  wr_set,
  input  logic              wr_e,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_g,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  output logic [SET_W-1:0]  lk_set,
  output logic              hit,
  output logic [WAY_W-1:0]  way
);

  logic [SA_WAYS-1:0] way_match;

  assign lk_set = SET_W'(page_pair_no(64'(lk_va), gps));

  for (genvar w = 0; w < SA_WAYS; w++) begin : g_way
    logic              e_q    [SA_SETS];
    logic [TAG_W-1:0]  tag_q  [SA_SETS];
    logic [ASID_W-1:0] asid_q [SA_SETS];
    logic              g_q    [SA_SETS];
    logic              wr_here;

    assign wr_here = wr_en && (wr_way == WAY_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SA_SETS; s++) e_q[s] <= 1'b0;
      end else if (wr_here) begin
        e_q[wr_set] <= wr_e;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_here) begin
        tag_q[wr_set]  <= wr_tag;
        asid_q[wr_set] <= wr_asid;
        g_q[wr_set]    <= wr_g;
      end
    end

    assign way_match[w] = entry_hit(e_q[lk_set], g_q[lk_set], asid_q[lk_set] == lk_asid,
                                    64'(lk_va), 64'(tag_q[lk_set]), gps);
  end

  always_comb begin
    hit = |way_match;
    way = '0;
    for (int w = SA_WAYS - 1; w >= 0; w--) begin
      if (way_match[w]) way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/tlb_fa_section.sv
module tlb_fa_section
  import tlb_lookup_pkg::*;
#(
  parameter int VA_W       = 48,
  parameter int ASID_W     = 10,
  parameter int FA_ENTRIES = 64,
  localparam int SLOT_W    = $clog2(FA_ENTRIES),
  localparam int TAG_W     = VA_W - TAG_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_e,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [5:0]        wr_ps,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_g,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              hit,
  output logic [SLOT_W-1:0] slot
);

  logic [FA_ENTRIES-1:0] slot_match;

  for (genvar k = 0; k < FA_ENTRIES; k++) begin : g_slot
    logic              e_q;
    logic [TAG_W-1:0]  tag_q;
    logic [5:0]        ps_q;
    logic [ASID_W-1:0] asid_q;
    logic              g_q;
    logic              wr_here;

    assign wr_here = wr_en && (wr_slot == SLOT_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       e_q <= 1'b0;
      else if (wr_here) e_q <= wr_e;
    end

    always_ff @(posedge clk) begin
      if (wr_here) begin
        tag_q  <= wr_tag;
        ps_q   <= wr_ps;
        asid_q <= wr_asid;
        g_q    <= wr_g;
      end
    end

    assign slot_match[k] = entry_hit(e_q, g_q, asid_q == lk_asid,
                                     64'(lk_va), 64'(tag_q), ps_q);
  end

  always_comb begin
    hit  = |slot_match;
    slot = '0;
    for (int k = FA_ENTRIES - 1; k >= 0; k--) begin
      if (slot_match[k]) slot = SLOT_W'(k);
    end
  end

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_lookup_pkg::*;
#(
  parameter int VA_W       = 48,
  parameter int ASID_W     = 10,
  parameter int SA_WAYS    = 8,
  parameter int SA_SETS    = 256,
  parameter int FA_ENTRIES = 64,
  localparam int SET_W     = $clog2(SA_SETS),
  localparam int WAY_W     = $clog2(SA_WAYS),
  localparam int SLOT_W    = $clog2(FA_ENTRIES),
  localparam int SA_TOTAL  = SA_WAYS * SA_SETS,
  localparam int IDX_W     = $clog2(SA_TOTAL + FA_ENTRIES),
  localparam int TAG_W     = VA_W - TAG_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        cfg_sa_ps,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_e,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [5:0]        wr_ps,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_g,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_idx
);

  // write decode by flat index
  logic              wr_to_sa, wr_to_fa;
  logic [IDX_W-1:0]  fa_off;
  assign wr_to_sa = wr_en && (wr_idx < IDX_W'(SA_TOTAL));
  assign wr_to_fa = wr_en && (wr_idx >= IDX_W'(SA_TOTAL))
                          && (wr_idx < IDX_W'(SA_TOTAL + FA_ENTRIES));
  assign fa_off   = wr_idx - IDX_W'(SA_TOTAL);

  // named internal events
  logic              sa_hit, fa_hit;
  logic [WAY_W-1:0]  sa_way;
  logic [SET_W-1:0]  sa_set;
  logic [SLOT_W-1:0] fa_slot;
  logic [IDX_W-1:0]  hit_idx;

  tlb_sa_section #(.VA_W(VA_W), .ASID_W(ASID_W), .SA_WAYS(SA_WAYS), .SA_SETS(SA_SETS)) u_sa (
    .clk     (clk),
    .rst_n   (rst_n),
    .gps     (cfg_sa_ps),
    .wr_en   (wr_to_sa),
    .wr_way  (wr_idx[SET_W +: WAY_W]),
    .wr_set  (wr_idx[SET_W-1:0]),
    .wr_e    (wr_e),
    .wr_tag  (wr_tag),
    .wr_asid (wr_asid),
    .wr_g    (wr_g),
    .lk_va   (lk_va),
    .lk_asid (lk_asid),
    .lk_set  (sa_set),
    .hit     (sa_hit),
    .way     (sa_way)
  );

  tlb_fa_section #(.VA_W(VA_W), .ASID_W(ASID_W), .FA_ENTRIES(FA_ENTRIES)) u_fa (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_to_fa),
    .wr_slot (fa_off[SLOT_W-1:0]),
    .wr_e    (wr_e),
    .wr_tag  (wr_tag),
    .wr_ps   (wr_ps),
    .wr_asid (wr_asid),
    .wr_g    (wr_g),
    .lk_va   (lk_va),
    .lk_asid (lk_asid),
    .hit     (fa_hit),
    .slot    (fa_slot)
  );

  always_comb begin
    if (sa_hit)      hit_idx = (IDX_W'(sa_way) << SET_W) | IDX_W'(sa_set);
    else if (fa_hit) hit_idx = IDX_W'(SA_TOTAL) + IDX_W'(fa_slot);
    else             hit_idx = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && (sa_hit || fa_hit);
      rsp_idx   <= lk_valid ? hit_idx : '0;
    end
  end

endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk #(
  parameter int IDX_W      = 12,
  parameter int SA_TOTAL   = 2048,
  parameter int FA_ENTRIES = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             sa_hit,
  input logic             fa_hit,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [IDX_W-1:0] rsp_idx
);

  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_valid && !rsp_hit && rsp_idx == '0));

  a_r10_miss_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_idx == '0);

  a_r8_sa_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && sa_hit) |=> (rsp_hit && rsp_idx < IDX_W'(SA_TOTAL)));

  a_r9_pool_range: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !sa_hit && fa_hit) |=>
      (rsp_hit && rsp_idx >= IDX_W'(SA_TOTAL) && rsp_idx < IDX_W'(SA_TOTAL + FA_ENTRIES)));

  a_r10_no_match_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !sa_hit && !fa_hit) |=> !rsp_hit);

endmodule

bind tlb_lookup tlb_lookup_chk #(
  .IDX_W(IDX_W), .SA_TOTAL(SA_TOTAL), .FA_ENTRIES(FA_ENTRIES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .sa_hit    (sa_hit),
  .fa_hit    (fa_hit),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_idx   (rsp_idx)
);

// File: tb/tlb_lookup_tb.sv
`timescale 1ns/1ps
module tlb_lookup_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cfg_sa_ps = 6'd14;
  logic        wr_en = 1'b0;
  logic [11:0] wr_idx = '0;
  logic        wr_e = 1'b0;
  logic [34:0] wr_tag = '0;
  logic [5:0]  wr_ps = '0;
  logic [9:0]  wr_asid = '0;
  logic        wr_g = 1'b0;
  logic        lk_valid = 1'b0;
  logic [47:0] lk_va = '0;
  logic [9:0]  lk_asid = '0;
  logic        rsp_valid, rsp_hit;
  logic [11:0] rsp_idx;

  int checks = 0;
  int fails  = 0;

  tlb_lookup u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_sa_ps(cfg_sa_ps),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_e(wr_e), .wr_tag(wr_tag), .wr_ps(wr_ps),
    .wr_asid(wr_asid), .wr_g(wr_g),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx)
  );

  always #5 clk = ~clk;

  // address with high part, set bits [22:15] and odd-page bit 14 (shared size 14)
  function automatic logic [47:0] mkva(input logic [24:0] hi, input logic [7:0] set,
                                       input logic odd);
    return {hi, set, odd, 14'd0};
  endfunction

  task automatic put(input int idx, input logic e, input logic [47:0] va,
                     input logic [5:0] ps, input logic [9:0] asid, input logic g);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 12'(idx); wr_e = e; wr_tag = va[47:13];
    wr_ps = ps; wr_asid = asid; wr_g = g;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic note(input logic ok, input string req, input string what,
                      input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic look(input logic [47:0] va, input logic [9:0] asid,
                      input logic ehit, input int eidx, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va; lk_asid = asid;
    @(negedge clk);
    lk_valid = 1'b0;
    note(rsp_valid && rsp_hit == ehit && rsp_idx == 12'(eidx), req, "lookup",
         {rsp_hit, rsp_idx}, {ehit, 12'(eidx)});
  endtask

  initial begin : watchdog
    #1500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [47:0] a, b, c, d;
    a = mkva(25'h12345, 8'h5A, 1'b0);
    b = mkva(25'h0ABCD, 8'h10, 1'b0);
    c = mkva(25'h1FF00, 8'h20, 1'b0);
    d = mkva(25'h00777, 8'h30, 1'b0);

    repeat (3) @(negedge clk);
    note(!rsp_valid && !rsp_hit && rsp_idx == 0, "R1", "reset outputs",
         {rsp_valid, rsp_idx}, 13'd0);
    rst_n = 1'b1;
    look(a, 10'd7, 1'b0, 0, "R1");

    // basic set-associative hit, way 3 of set 0x5A
    put(3*256 + 'h5A, 1'b1, a, 6'd14, 10'd7, 1'b0);
    look(a, 10'd7, 1'b1, 858, "R3");
    @(negedge clk);
    note(!rsp_valid && !rsp_hit && rsp_idx == 0, "R2", "idle after response",
         {rsp_valid, rsp_idx}, 13'd0);
    look(a | 48'h4000, 10'd7, 1'b1, 858, "R4");
    look(a | 48'h3FFF, 10'd7, 1'b1, 858, "R4");
    look(mkva(25'h12345, 8'h5B, 1'b0), 10'd7, 1'b0, 0, "R3");
    look(a ^ 48'h8000_0000_0000, 10'd7, 1'b0, 0, "R4");
    look(a, 10'd8, 1'b0, 0, "R5");

    put(1*256 + 'h5A, 1'b1, a, 6'd14, 10'd9, 1'b1);
    look(a, 10'd8, 1'b1, 346, "R5");
    look(a, 10'd7, 1'b1, 346, "R7");
    put(0*256 + 'h5A, 1'b0, a, 6'd14, 10'd7, 1'b1);
    look(a, 10'd7, 1'b1, 346, "R6");

    // written size 12 would compare bit 14; the shared size 14 must be used
    put(5*256 + 'h10, 1'b1, b, 6'd12, 10'd7, 1'b0);
    look(b | 48'h4000, 10'd7, 1'b1, 1296, "R11");

    // pool entries with their own size 20
    put(2048 + 5, 1'b1, c, 6'd20, 10'd7, 1'b0);
    look(c | 48'h1F_FFFF, 10'd7, 1'b1, 2053, "R9");
    look(c ^ 48'h20_0000, 10'd7, 1'b0, 0, "R9");
    put(2048 + 2, 1'b1, c, 6'd20, 10'd7, 1'b0);
    look(c, 10'd7, 1'b1, 2050, "R9");
    put(6*256 + 'h20, 1'b1, c, 6'd14, 10'd7, 1'b0);
    look(c, 10'd7, 1'b1, 1568, "R8");

    // write and lookup captured at the same edge
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 12'(2048 + 7); wr_e = 1'b1; wr_tag = d[47:13];
    wr_ps = 6'd14; wr_asid = 10'd7; wr_g = 1'b0;
    lk_valid = 1'b1; lk_va = d; lk_asid = 10'd7;
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
    note(rsp_valid && !rsp_hit && rsp_idx == 0, "R12", "same-edge lookup",
         {rsp_hit, rsp_idx}, 13'd0);
    look(d, 10'd7, 1'b1, 2055, "R12");

    // clear directed entries
    put(858, 1'b0, a, 6'd14, 10'd0, 1'b0);
    put(346, 1'b0, a, 6'd14, 10'd0, 1'b0);
    put(1296, 1'b0, b, 6'd14, 10'd0, 1'b0);
    put(2053, 1'b0, c, 6'd14, 10'd0, 1'b0);
    put(2050, 1'b0, c, 6'd14, 10'd0, 1'b0);
    put(1568, 1'b0, c, 6'd14, 10'd0, 1'b0);
    put(2055, 1'b0, d, 6'd14, 10'd0, 1'b0);
    look(a, 10'd7, 1'b0, 0, "R10");
    look(c, 10'd7, 1'b0, 0, "R10");

    // sweep every set, way chosen by set number
    for (int s = 0; s < 256; s++) begin
      put((s % 8) * 256 + s, 1'b1, mkva(25'(s * 37 + 5), 8'(s), 1'(s & 1)),
          6'd14, 10'(s), 1'b0);
    end
    for (int s = 0; s < 256; s++) begin
      look(mkva(25'(s * 37 + 5), 8'(s), 1'b1), 10'(s), 1'b1, (s % 8) * 256 + s, "R3");
      look(mkva(25'(s * 37 + 5), 8'(s), 1'b0), 10'(s ^ 1), 1'b0, 0, "R5");
    end

    // sweep every pool slot with sizes 12..21
    for (int k = 0; k < 64; k++) begin
      put(2048 + k, 1'b1, 48'(k + 100) << 35, 6'(12 + k % 10), 10'd1000, 1'b0);
    end
    for (int k = 0; k < 64; k++) begin
      logic [47:0] base, low;
      int ps;
      ps   = 12 + k % 10;
      base = 48'(k + 100) << 35;
      low  = (48'd1 << (ps + 1)) - 48'd1;
      look(base | low, 10'd1000, 1'b1, 2048 + k, "R9");
      look(base | (48'd1 << (ps + 1)), 10'd1000, 1'b0, 0, "R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule